// File: doc/BRIEF.md
# Trigger Pin Polarity Mapper

This block connects one trigger input and one sync output to a bank of general-purpose external pins. Each pin has a two-bit code in each of two configuration words. The source word chooses which pins feed the incoming trigger and at which level each one counts as asserted. The destination word chooses which pins carry the outgoing sync pulse and with which polarity.

On the input side, every pin passes through a two-flop synchronizer. After that, each active pin is corrected for its polarity, and the active pins are OR-ed into a single trigger level. The block registers that level and also produces a one-cycle event on its rising edge. On the output side, the mapping is purely combinational. A pin that is not selected rests at 0. A selected pin copies the sync pulse, or its inverse when the pin is active-low. Software loads each word through a single-cycle write strobe with a one-bit select.

Top module: `trig_pin_map`

## Requirements
- R1: After reset, both configuration words are 0. Every pin_out bit is 0, and trig_level and trig_event are 0.
- R2: The code for pin i sits at cfg_wdata bits [2i+1:2i]. In the source word, code 2'b11 makes pin i active-high: a synchronized pin_in[i] of 1 asserts the trigger level.
- R3: In the source word, code 2'b10 makes pin i active-low: a synchronized pin_in[i] of 0 asserts the trigger level.
- R4: In the source word, codes 2'b00 and 2'b01 make pin i a don't-care, so its input never affects trig_level or trig_event.
- R5: In the destination word, code 2'b11 makes pin_out[i] equal sync_pulse, with no register in the path.
- R6: In the destination word, code 2'b10 makes pin_out[i] equal the inverse of sync_pulse.
- R7: In the destination word, codes 2'b00 and 2'b01 hold pin_out[i] at 0 whatever sync_pulse does.
- R8: trig_level is the OR of all active source pins after polarity correction. It appears three clock edges after a pin_in change: two synchronizer edges plus one register edge.
- R9: trig_event is high for exactly one cycle, in the same cycle in which trig_level rises from 0 to 1.
- R10: A write with cfg_sel=0 loads the source word and a write with cfg_sel=1 loads the destination word. Either write leaves the other word unchanged, and the new word applies from the following cycle.
- R11: Writing 0 to a word returns every pin of that direction to the inactive state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = source word, 1 = destination word |
| cfg_wdata | input | 2*NPINS | Packed two-bit codes, pin i at bits [2i+1:2i] |
| pin_in | input | NPINS | Raw external pin inputs |
| sync_pulse | input | 1 | Sync pulse to drive onto destination pins |
| pin_out | output | NPINS | Pin output levels |
| trig_level | output | 1 | Registered combined trigger level |
| trig_event | output | 1 | One-cycle pulse on trigger rise |

## Verification
The bench builds the block with its default of ten pins, so the whole 20-bit code word is exercised, including the highest pin position. Directed phases cover the usual setup: pin 7 as an active-high input and pin 6 as an active-high output. Further directed phases cover active-low pins, words made entirely of don't-care codes, mixed output codes, and clearing a word by writing 0. A random phase then reloads both words while the pins toggle. This reaches OR combinations of several inputs and configuration changes that themselves create trigger edges.

// File: rtl/trig_pin_map.sv
module trig_pin_map #(
  parameter int NPINS = 10,
  localparam int CW = 2 * NPINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CW-1:0]    cfg_wdata,
  input  logic [NPINS-1:0] pin_in,
  input  logic             sync_pulse,
  output logic [NPINS-1:0] pin_out,
  output logic             trig_level,
  output logic             trig_event
);

  logic [CW-1:0]    src_map, dst_map;
  logic [NPINS-1:0] meta_q, sync_q, hit;
  logic             lvl_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_map <= '0;
      dst_map <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) dst_map <= cfg_wdata;
      else         src_map <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign hit[g]     = src_map[2*g+1] & ~(sync_q[g] ^ src_map[2*g]);
    assign pin_out[g] = dst_map[2*g+1] & ~(sync_pulse ^ dst_map[2*g]);
  end

  assign lvl_now = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_level <= 1'b0;
      trig_event <= 1'b0;
    end else begin
      trig_level <= lvl_now;
      trig_event <= lvl_now & ~trig_level;
    end
  end

endmodule

// File: rtl/trig_pin_map_chk.sv
module trig_pin_map_chk #(
  parameter int NPINS = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic               cfg_sel,
  input logic [2*NPINS-1:0] src_map,
  input logic [2*NPINS-1:0] dst_map,
  input logic               sync_pulse,
  input logic [NPINS-1:0]   pin_out,
  input logic               trig_level,
  input logic               trig_event
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (pin_out == '0 && !trig_event && !trig_level);
    end
  end

  assert_event_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_event |=> !trig_event);

  assert_event_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_event |-> (trig_level && !$past(trig_level)));

  assert_src_write_keeps_dst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> $stable(dst_map));

  assert_dst_write_keeps_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> $stable(src_map));

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    assert_out_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_map[2*g+1:2*g] == 2'b11) |-> (pin_out[g] == sync_pulse));
    assert_out_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_map[2*g+1:2*g] == 2'b10) |-> (pin_out[g] == !sync_pulse));
    assert_out_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!dst_map[2*g+1]) |-> !pin_out[g]);
  end

endmodule

bind trig_pin_map trig_pin_map_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .src_map(src_map), .dst_map(dst_map), .sync_pulse(sync_pulse),
  .pin_out(pin_out), .trig_level(trig_level), .trig_event(trig_event)
);

// File: tb/sim_trig_pin_map.sv
`timescale 1ns/1ps
module sim_trig_pin_map;
  localparam int N = 10;
  localparam int W = 2 * N;

  logic clk = 0, rst_n = 0, cfg_we = 0, cfg_sel = 0, sync_pulse = 0;
  logic [W-1:0] cfg_wdata = '0;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out;
  logic trig_level, trig_event;

  int n_run = 0, n_fail = 0;
  string tag = "R1";
  bit live = 0;

  logic [W-1:0] m_src = '0, m_dst = '0;
  logic [N-1:0] m_s1 = '0, m_s2 = '0;
  logic m_lvl = 0, m_evt = 0;

  always #2.5 clk = ~clk;

  trig_pin_map u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pin_in(pin_in), .sync_pulse(sync_pulse),
    .pin_out(pin_out), .trig_level(trig_level), .trig_event(trig_event));

  function automatic logic level_of(logic [W-1:0] map, logic [N-1:0] p);
    logic r = 0;
    for (int i = 0; i < N; i++) begin
      int code = map[2*i +: 2];
      if (code == 3 && p[i] == 1'b1) r = 1;
      if (code == 2 && p[i] == 1'b0) r = 1;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] outs_of(logic [W-1:0] map, logic pulse);
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      int code = map[2*i +: 2];
      if (code == 3) r[i] = pulse;
      else if (code == 2) r[i] = !pulse;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = '0; m_dst = '0; m_s1 = '0; m_s2 = '0; m_lvl = 0; m_evt = 0;
    end else begin
      logic now;
      now = level_of(m_src, m_s2);
      m_evt = now & !m_lvl;
      m_lvl = now;
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (cfg_we) begin
        if (cfg_sel) m_dst = cfg_wdata; else m_src = cfg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (live) begin
      logic [N-1:0] eo;
      eo = outs_of(m_dst, sync_pulse);
      n_run += 3;
      if (pin_out !== eo) begin
        n_fail++; $display("FAIL %s pin_out act=%h exp=%h", tag, pin_out, eo);
      end
      if (trig_level !== m_lvl) begin
        n_fail++; $display("FAIL %s trig_level act=%b exp=%b", tag, trig_level, m_lvl);
      end
      if (trig_event !== m_evt) begin
        n_fail++; $display("FAIL %s trig_event act=%b exp=%b", tag, trig_event, m_evt);
      end
    end
  end

  task automatic tick(input logic [N-1:0] p, input logic s);
    @(negedge clk); #1;
    cfg_we = 0; pin_in = p; sync_pulse = s;
  endtask

  task automatic wr(input logic sel, input logic [W-1:0] d);
    @(negedge clk); #1;
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); #1;
    cfg_we = 0;
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tag = "R1";
    live = 1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    for (int i = 0; i < 4; i++) tick(N'(i * 97), i[0]);

    tag = "R2";                         // pin7 source 11, pin6 dest 11
    wr(0, W'(3) << 14);
    wr(1, W'(3) << 12);
    for (int i = 0; i < 16; i++) tick((i % 5 < 2) ? N'(1 << 7) : N'(i * 13 & 10'h37f), i[1]);

    tag = "R3";                         // pin2 active-low on top of pin7
    wr(0, (W'(3) << 14) | (W'(2) << 4));
    for (int i = 0; i < 16; i++) tick(N'(10'h004) | ((i % 6 < 3) ? N'(0) : N'(10'h004)), i[0]);

    tag = "R8";
    for (int i = 0; i < 12; i++) tick((i % 4 == 0) ? N'(10'h080) : N'(10'h004), 0);

    tag = "R4";                         // all don't-care
    wr(0, 20'h55555);
    for (int i = 0; i < 12; i++) tick(i[0] ? '1 : '0, i[1]);
    wr(0, 20'h00000);
    for (int i = 0; i < 8; i++) tick(i[0] ? '1 : '0, 0);

    tag = "R5_R6_R7";                   // pins 0..3 codes 11,10,01,00
    wr(1, 20'h0003 | (20'h2 << 2) | (20'h1 << 4));
    for (int i = 0; i < 8; i++) tick('0, i[0]);

    tag = "R10";
    wr(0, W'(3) << 18);
    for (int i = 0; i < 8; i++) tick(i[2] ? N'(10'h200) : N'(0), i[0]);

    tag = "R11";
    wr(1, '0);
    for (int i = 0; i < 6; i++) tick(i[1] ? N'(10'h200) : N'(0), i[0]);
    wr(0, '0);
    for (int i = 0; i < 6; i++) tick(i[0] ? '1 : '0, i[0]);

    tag = "R9";
    for (int i = 0; i < 400; i++) begin
      if (i % 37 == 0) wr(i[0], W'($urandom));
      tick(N'($urandom), 1'($urandom));
    end

    repeat (2) @(negedge clk);
    live = 0;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule